// File: doc/BRIEF.md
# SIMD Branch Divergence Mask Unit

This block sits beside the single fetch/decode unit of a group of parallel lanes that all execute the same instruction each cycle. When the instruction stream reaches an if/else region, every lane has already evaluated the branch condition for itself, giving a per-lane true/false vector. The unit turns that vector into lane enable masks. The taken path runs first with only the lanes that were true and enabled. The else path then runs with only the lanes that were false and enabled. When the region closes, every lane that was enabled before the branch is enabled again for the shared code that follows.

The sequencer drives three strobes, one per region marker, and presents the condition vector with the if strobe and again with the else strobe. Outside any region the output mask passes the externally supplied active mask straight through. A small last-in first-out store of saved masks allows regions to nest. After each if or else strobe a skip flag tells the sequencer whether the path about to run has no enabled lane at all, so that it can jump over that path. Illegal strobe use raises an error flag that stays set until reset and changes nothing else.

Top module: `divmask_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, no region is open, `lane_mask_o` equals `active_i`, and `skip_o` and `err_o` are 0.
- R2: With no region open, `lane_mask_o` follows `active_i` in the same cycle, with no register in the path.
- R3: A legal if strobe saves the mask shown on `lane_mask_o` and, from the next cycle, shows that mask ANDed with `cond_i`.
- R4: A legal else strobe shows, from the next cycle, the innermost saved mask ANDed with the complement of `cond_i`.
- R5: A legal endif strobe removes the innermost saved mask and shows it from the next cycle. When this closes the outermost region, `lane_mask_o` again follows `active_i`.
- R6: From the cycle after an if or else strobe, `skip_o` is 1 exactly when the new mask is all zero. An endif strobe clears `skip_o`.
- R7: Up to `DEPTH` (default 4) regions can be nested. Endif strobes restore the saved masks in reverse order of saving.
- R8: An if strobe while `DEPTH` regions are open sets `err_o`. The saved masks, the number of open regions, `lane_mask_o` and `skip_o` stay unchanged.
- R9: An else or endif strobe while no region is open sets `err_o` and changes nothing else.
- R10: Two or more strobes in the same cycle set `err_o` and change nothing else.
- R11: `err_o` stays 1 until reset, and legal strobes continue to work after it is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| active_i | input | LANES | Lanes enabled outside any region |
| cond_i | input | LANES | Per-lane branch condition, 1 = true |
| if_i | input | 1 | Strobe: open a region, taken path follows |
| else_i | input | 1 | Strobe: switch to the else path |
| endif_i | input | 1 | Strobe: close the innermost region |
| lane_mask_o | output | LANES | Current lane enable mask |
| skip_o | output | 1 | Path about to run has no enabled lane |
| err_o | output | 1 | Sticky: illegal strobe or stack overflow or underflow seen |

## Verification
Two functions can take effect in the same cycle: the register update made by an endif that closes the outermost region, and the direct pass-through of `active_i`. The bench closes a region after loading a saved mask that differs from `active_i`, then changes `active_i` while no region is open. It checks that the output takes the new `active_i` value and not the register contents. The same clash appears when an overflowing if strobe meets a full store: after the rejected strobe, the bench unwinds every level and judges each restored mask against the order in which the masks were saved.

// File: rtl/divmask_pkg.sv
package divmask_pkg;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_IF    = 3'd1,
        CMD_ELSE  = 3'd2,
        CMD_ENDIF = 3'd3,
        CMD_BAD   = 3'd4
    } div_cmd_e;

    function automatic logic [1:0] strobe_count(input logic a, input logic b, input logic c);
        return {1'b0, a} + {1'b0, b} + {1'b0, c};
    endfunction

endpackage

// File: rtl/divmask_decode.sv
module divmask_decode
    import divmask_pkg::*;
(
    input  logic     if_i,
    input  logic     else_i,
    input  logic     endif_i,
    input  logic     full_i,
    input  logic     empty_i,
    output div_cmd_e cmd_o
);

    logic [1:0] n_strobes;

    always_comb begin
        n_strobes = strobe_count(if_i, else_i, endif_i);
        cmd_o     = CMD_NONE;
        if (n_strobes > 2'd1) begin
            cmd_o = CMD_BAD;
        end else if (if_i) begin
            cmd_o = full_i ? CMD_BAD : CMD_IF;
        end else if (else_i) begin
            cmd_o = empty_i ? CMD_BAD : CMD_ELSE;
        end else if (endif_i) begin
            cmd_o = empty_i ? CMD_BAD : CMD_ENDIF;
        end
    end

endmodule

// File: rtl/divmask_stack.sv
module divmask_stack #(
    parameter int LANES = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [LANES-1:0] wdata_i,
    output logic [LANES-1:0] top_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam int LW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LW-1:0]    level_q;
    logic [LW-1:0]    top_idx;
    logic [LANES-1:0] entry_q [DEPTH];

    assign full_o  = (level_q == LW'(DEPTH));
    assign empty_o = (level_q == '0);
    assign top_idx = level_q - LW'(1);
    assign top_o   = empty_o ? '0 : entry_q[top_idx[IW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else if (push_i && !full_o) begin
            level_q <= level_q + LW'(1);
        end else if (pop_i && !empty_o) begin
            level_q <= level_q - LW'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (push_i && !full_o && (level_q == LW'(g))) begin
                entry_q[g] <= wdata_i;
            end
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level_q <= LW'(DEPTH)) else $error("stack level beyond depth"); // R7

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (push_i && !full_o) |=> (level_q == $past(level_q) + LW'(1))) else $error("push did not grow"); // R7

endmodule

// File: rtl/divmask_unit.sv
module divmask_unit
    import divmask_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] active_i,
    input  logic [LANES-1:0] cond_i,
    input  logic             if_i,
    input  logic             else_i,
    input  logic             endif_i,
    output logic [LANES-1:0] lane_mask_o,
    output logic             skip_o,
    output logic             err_o
);

    div_cmd_e         cmd;
    logic             full;
    logic             empty;
    logic [LANES-1:0] saved_top;
    logic [LANES-1:0] cur_q;
    logic [LANES-1:0] eff_mask;
    logic [LANES-1:0] next_mask;
    logic             skip_q;
    logic             err_q;

    divmask_decode u_decode (
        .if_i    (if_i),
        .else_i  (else_i),
        .endif_i (endif_i),
        .full_i  (full),
        .empty_i (empty),
        .cmd_o   (cmd)
    );

    divmask_stack #(
        .LANES (LANES),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk     (clk),
        .rst     (rst),
        .push_i  (cmd == CMD_IF),
        .pop_i   (cmd == CMD_ENDIF),
        .wdata_i (eff_mask),
        .top_o   (saved_top),
        .full_o  (full),
        .empty_o (empty)
    );

    assign eff_mask = empty ? active_i : cur_q;

    always_comb begin
        next_mask = cur_q;
        unique case (cmd)
            CMD_IF:    next_mask = eff_mask & cond_i;
            CMD_ELSE:  next_mask = saved_top & ~cond_i;
            CMD_ENDIF: next_mask = saved_top;
            default:   next_mask = cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            skip_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            cur_q <= next_mask;
            if (cmd == CMD_IF || cmd == CMD_ELSE) begin
                skip_q <= (next_mask == '0);
            end else if (cmd == CMD_ENDIF) begin
                skip_q <= 1'b0;
            end
            if (cmd == CMD_BAD) begin
                err_q <= 1'b1;
            end
        end
    end

    assign lane_mask_o = eff_mask;
    assign skip_o      = skip_q;
    assign err_o       = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q) else $error("error flag dropped"); // R11

    AST_IF_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_IF) |=> ((cur_q & ~$past(eff_mask)) == '0)) else $error("if enabled a new lane"); // R3

    AST_ELSE_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ELSE) |=> ((cur_q & $past(cond_i)) == '0)) else $error("else kept a true lane"); // R4

    AST_ENDIF_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ENDIF) |=> (cur_q == $past(saved_top))) else $error("endif did not restore"); // R5

    AST_SKIP_ZERO: assert property (@(posedge clk) disable iff (rst)
        skip_q |-> (cur_q == '0)) else $error("skip with lanes enabled"); // R6

    AST_BAD_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_BAD) |=> ($stable(cur_q) && $stable(skip_q) && $stable(full) && $stable(empty))) else $error("illegal strobe changed state"); // R10

    AST_BAD_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_BAD) |=> err_q) else $error("illegal strobe missed"); // R8

endmodule

// File: tb/divmask_unit_tb.sv
`timescale 1ns/1ps
module divmask_unit_tb;

    localparam int LANES = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] active_i = 8'hFF;
    logic [LANES-1:0] cond_i = '0;
    logic             if_i = 1'b0;
    logic             else_i = 1'b0;
    logic             endif_i = 1'b0;
    logic [LANES-1:0] lane_mask_o;
    logic             skip_o;
    logic             err_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    divmask_unit #(.LANES(LANES), .DEPTH(4)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .active_i    (active_i),
        .cond_i      (cond_i),
        .if_i        (if_i),
        .else_i      (else_i),
        .endif_i     (endif_i),
        .lane_mask_o (lane_mask_o),
        .skip_o      (skip_o),
        .err_o       (err_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
    endtask

    // Apply one cycle of strobes; return 1 ns after the capturing edge.
    task automatic strobe(input logic i, input logic e, input logic d, input logic [LANES-1:0] c);
        @(negedge clk);
        if_i = i; else_i = e; endif_i = d; cond_i = c;
        @(posedge clk);
        #1;
        if_i = 1'b0; else_i = 1'b0; endif_i = 1'b0;
    endtask

    task automatic t_reset();
        active_i = 8'hFF;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mask in reset", lane_mask_o, 8'hFF);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        check("R1 mask after reset", lane_mask_o, 8'hFF);
        check("R1 skip", skip_o, 0);
        check("R1 err", err_o, 0);
        active_i = 8'h5A;
        #0.5;
        check("R2 pass-through", lane_mask_o, 8'h5A);
    endtask

    task automatic t_basic();
        active_i = 8'hFF;
        strobe(1, 0, 0, 8'h07);
        check("R3 if mask", lane_mask_o, 8'h07);
        check("R6 if nonzero skip", skip_o, 0);
        strobe(0, 1, 0, 8'h07);
        check("R4 else mask", lane_mask_o, 8'hF8);
        strobe(0, 0, 1, 8'h00);
        check("R5 endif mask", lane_mask_o, 8'hFF);
        active_i = 8'h3C;
        #0.5;
        check("R5 outer pass-through after endif", lane_mask_o, 8'h3C);
        check("R9 no error on legal use", err_o, 0);
    endtask

    task automatic t_skip();
        active_i = 8'h0F;
        strobe(1, 0, 0, 8'hF0);
        check("R6 if empty mask", lane_mask_o, 8'h00);
        check("R6 if skip set", skip_o, 1);
        strobe(0, 1, 0, 8'hF0);
        check("R4 else after empty if", lane_mask_o, 8'h0F);
        check("R6 else skip clear", skip_o, 0);
        strobe(0, 0, 1, 8'h00);
        strobe(1, 0, 0, 8'h0F);
        strobe(0, 1, 0, 8'h0F);
        check("R6 else empty mask", lane_mask_o, 8'h00);
        check("R6 else skip set", skip_o, 1);
        strobe(0, 0, 1, 8'h00);
        check("R6 endif clears skip", skip_o, 0);
        check("R5 endif restores", lane_mask_o, 8'h0F);
    endtask

    task automatic t_nest();
        active_i = 8'hFF;
        strobe(1, 0, 0, 8'hAA);
        strobe(1, 0, 0, 8'h0F);
        check("R7 nested if", lane_mask_o, 8'h0A);
        strobe(0, 1, 0, 8'h0F);
        check("R7 nested else", lane_mask_o, 8'hA0);
        strobe(1, 0, 0, 8'h80);
        strobe(1, 0, 0, 8'h80);
        check("R7 depth four", lane_mask_o, 8'h80);
        check("R8 no error yet", err_o, 0);
        strobe(1, 0, 0, 8'h01);
        check("R8 overflow err", err_o, 1);
        check("R8 overflow mask kept", lane_mask_o, 8'h80);
        check("R8 overflow skip kept", skip_o, 0);
        strobe(0, 0, 1, 8'h00);
        check("R7 pop 4", lane_mask_o, 8'h80);
        strobe(0, 0, 1, 8'h00);
        check("R7 pop 3", lane_mask_o, 8'hA0);
        strobe(0, 0, 1, 8'h00);
        check("R7 pop 2", lane_mask_o, 8'hAA);
        active_i = 8'h11;
        strobe(0, 0, 1, 8'h00);
        check("R5 pop 1 to pass-through", lane_mask_o, 8'h11);
    endtask

    task automatic t_underflow();
        do_reset();
        active_i = 8'hC3;
        strobe(0, 1, 0, 8'hFF);
        check("R9 else underflow err", err_o, 1);
        check("R9 else underflow mask", lane_mask_o, 8'hC3);
        do_reset();
        strobe(0, 0, 1, 8'h00);
        check("R9 endif underflow err", err_o, 1);
        check("R9 endif underflow mask", lane_mask_o, 8'hC3);
        strobe(1, 0, 0, 8'h81);
        check("R9 stack untouched after underflow", lane_mask_o, 8'h81);
        strobe(0, 0, 1, 8'h00);
        check("R9 single level after underflow", lane_mask_o, 8'hC3);
    endtask

    task automatic t_multi();
        do_reset();
        active_i = 8'hFF;
        strobe(1, 1, 0, 8'h00);
        check("R10 multi strobe err", err_o, 1);
        check("R10 multi strobe mask", lane_mask_o, 8'hFF);
        check("R10 multi strobe skip", skip_o, 0);
        strobe(1, 0, 0, 8'h0F);
        check("R11 if after err", lane_mask_o, 8'h0F);
        strobe(1, 0, 1, 8'h00);
        check("R10 if+endif inside region", lane_mask_o, 8'h0F);
        strobe(0, 0, 1, 8'h00);
        check("R11 endif after err", lane_mask_o, 8'hFF);
        repeat (3) @(posedge clk);
        #1;
        check("R11 err sticky", err_o, 1);
        do_reset();
        check("R1 reset clears err", err_o, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_skip();
        t_nest();
        t_underflow();
        t_multi();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #50000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule